// File: doc/BRIEF.md
# Three-Way Split Carry-Less Polynomial Multiplier

This block multiplies two binary polynomials, each held as a 3K-bit vector with bit i as the coefficient of x^i. It returns their full carry-less product of 6K-1 bits. There is no reduction modulo any field polynomial, so the block can serve as the core of a wider field multiplier or a checksum or hash datapath, with reduction done by the logic that follows it.

Each operand is cut into three K-bit slices. The block forms the three slice-wise products and the three products of pairwise slice sums, which makes six K-by-K products in place of nine. Each of these is a plain AND/XOR schoolbook array. The diagonal products are gathered into one polynomial and multiplied by (x^2K + x^K + 1), which costs only XOR and shifts. The cross products are gathered into a second polynomial shifted up by K bits, and the two are XORed together. The block is purely combinational and holds no state.

Top module: `kara3_mul`

## Requirements
- R1: For every pair of operands, prod_o equals the carry-less (XOR-accumulated) product of a_i and b_i. Output bit n is the XOR over all i+j=n of a_i[i]&b_i[j], for operand widths 3K with K in {1, 2, 4}.
- R2: When either operand is all zeros, prod_o is all zeros.
- R3: When one operand is the constant polynomial 1 (only bit 0 set), prod_o equals the other operand, zero-extended to 6K-1 bits.
- R4: prod_o[0] equals a_i[0]&b_i[0], and prod_o[6K-2] equals a_i[3K-1]&b_i[3K-1].
- R5: The XOR of all bits of prod_o equals (XOR of all bits of a_i) AND (XOR of all bits of b_i). This is the product evaluated at x=1.
- R6: Swapping a_i and b_i leaves prod_o unchanged.
- R7: When b_i is x^j (only bit j set), prod_o equals a_i shifted left by j bit positions.
- R8: The result is correct at the slice boundaries. This covers operands with only one K-bit slice non-zero, with all bits set, and with a bit at each slice edge (positions K-1, K, 2K-1, 2K).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 3K | First operand polynomial, bit i is the coefficient of x^i |
| b_i | input | 3K | Second operand polynomial, bit i is the coefficient of x^i |
| prod_o | output | 6K-1 | Carry-less product of a_i and b_i |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the operand inputs and prod_o. The bench applies each operand pair just after a rising clock edge and compares prod_o at the following falling edge, half a period later, by which time the combinational logic has settled. Reference products come from a bitwise shift-and-XOR routine in the bench. Every operand pair is covered for K=1 and K=2, and random plus directed boundary pairs are used for K=4.

// File: rtl/kara3_pkg.sv
package kara3_pkg;
    localparam int NUM_PART = 3;
    localparam int NUM_SUB  = 2 * NUM_PART;
endpackage

// File: rtl/gf_school_mul.sv
module gf_school_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-2:0] z_o
);
    always_comb begin
        z_o = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                z_o[i+j] = z_o[i+j] ^ (x_i[i] & y_i[j]);
            end
        end
    end
endmodule

// File: rtl/gf_kara3_split.sv
module gf_kara3_split
    import kara3_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [NUM_PART*K-1:0]     op_i,
    output logic [NUM_SUB-1:0][K-1:0] sub_o
);
    logic [K-1:0] s_lo, s_mid, s_hi;

    always_comb begin
        s_lo  = op_i[K-1:0];
        s_mid = op_i[2*K-1:K];
        s_hi  = op_i[3*K-1:2*K];
        sub_o[0] = s_lo;
        sub_o[1] = s_mid;
        sub_o[2] = s_hi;
        sub_o[3] = s_mid ^ s_lo;
        sub_o[4] = s_hi ^ s_lo;
        sub_o[5] = s_hi ^ s_mid;
    end
endmodule

// File: rtl/gf_kara3_combine.sv
module gf_kara3_combine
    import kara3_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [NUM_SUB-1:0][2*K-2:0] sp_i,
    output logic [6*K-2:0]              prod_o
);
    localparam int OW  = 6 * K - 1;
    localparam int PW  = 2 * K - 1;
    localparam int PAD = OW - PW;

    logic [OW-1:0] diag_sum, cross_sum;

    always_comb begin
        diag_sum  = {{PAD{1'b0}}, sp_i[0]}
                  ^ ({{PAD{1'b0}}, sp_i[1]} << K)
                  ^ ({{PAD{1'b0}}, sp_i[2]} << (2 * K));
        cross_sum = {{PAD{1'b0}}, sp_i[3]}
                  ^ ({{PAD{1'b0}}, sp_i[4]} << K)
                  ^ ({{PAD{1'b0}}, sp_i[5]} << (2 * K));
        prod_o = diag_sum
               ^ (diag_sum << K)
               ^ (diag_sum << (2 * K))
               ^ (cross_sum << K);
    end
endmodule

// File: rtl/kara3_mul.sv
module kara3_mul
    import kara3_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [3*K-1:0] a_i,
    input  logic [3*K-1:0] b_i,
    output logic [6*K-2:0] prod_o
);
    logic [NUM_SUB-1:0][K-1:0]   a_sub, b_sub;
    logic [NUM_SUB-1:0][2*K-2:0] sub_prod;

    gf_kara3_split #(.K(K)) u_split_a (.op_i(a_i), .sub_o(a_sub));
    gf_kara3_split #(.K(K)) u_split_b (.op_i(b_i), .sub_o(b_sub));

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        gf_school_mul #(.W(K)) u_mul (
            .x_i(a_sub[g]),
            .y_i(b_sub[g]),
            .z_o(sub_prod[g])
        );
    end

    gf_kara3_combine #(.K(K)) u_comb (.sp_i(sub_prod), .prod_o(prod_o));
endmodule

// File: rtl/kara3_mul_chk.sv
module kara3_mul_chk #(
    parameter int K = 4
) (
    input logic [3*K-1:0] a_i,
    input logic [3*K-1:0] b_i,
    input logic [6*K-2:0] prod_o
);
    always_comb begin
        if (!$isunknown({a_i, b_i, prod_o})) begin
            // R2
            a_r2_zero_operand: assert (!((a_i == '0) || (b_i == '0)) || (prod_o == '0))
                else $error("zero operand gave non-zero product");
            // R3
            a_r3_unit_operand: assert ((b_i != 1) || (prod_o == {{(3*K-1){1'b0}}, a_i}))
                else $error("unit operand did not pass other operand");
            // R4
            a_r4_low_bit: assert (prod_o[0] == (a_i[0] & b_i[0]))
                else $error("low product bit wrong");
            a_r4_top_bit: assert (prod_o[6*K-2] == (a_i[3*K-1] & b_i[3*K-1]))
                else $error("top product bit wrong");
            // R5
            a_r5_eval_at_one: assert ((^prod_o) == ((^a_i) & (^b_i)))
                else $error("product parity mismatch");
        end
    end
endmodule

bind kara3_mul kara3_mul_chk #(.K(K)) u_chk (.a_i(a_i), .b_i(b_i), .prod_o(prod_o));

// File: tb/test_kara3_mul.sv
`timescale 1ns/1ps
module test_kara3_mul;
    localparam int KB = 4;
    localparam int WB = 3 * KB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [WB-1:0]     a, b;
    logic [2*WB-2:0]   p;
    logic [2:0]        a1, b1;
    logic [4:0]        p1;
    logic [5:0]        a2, b2;
    logic [10:0]       p2;

    kara3_mul #(.K(KB)) i_kara3_mul    (.a_i(a),  .b_i(b),  .prod_o(p));
    kara3_mul #(.K(1))  i_kara3_mul_k1 (.a_i(a1), .b_i(b1), .prod_o(p1));
    kara3_mul #(.K(2))  i_kara3_mul_k2 (.a_i(a2), .b_i(b2), .prod_o(p2));

    function automatic logic [63:0] clmul(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] r = '0;
        for (int i = 0; i < 32; i++)
            if (y[i]) r = r ^ ({32'd0, x} << i);
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply_b(input logic [WB-1:0] x, input logic [WB-1:0] y);
        @(posedge clk); a = x; b = y;
        @(negedge clk);
    endtask

    task automatic run_pair(input string tag, input logic [WB-1:0] x, input logic [WB-1:0] y);
        apply_b(x, y);
        check(tag, {41'd0, p}, clmul({20'd0, x}, {20'd0, y}));
    endtask

    task automatic t_rest;
        apply_b('0, '0);
        check("R2 idle zero", {41'd0, p}, 64'd0);
    endtask

    task automatic t_zero;
        apply_b('0, 12'hABC); check("R2 a zero", {41'd0, p}, 64'd0);
        apply_b(12'hFFF, '0); check("R2 b zero", {41'd0, p}, 64'd0);
    endtask

    task automatic t_unit;
        apply_b(12'h9A5, 12'd1); check("R3 b one", {41'd0, p}, 64'h9A5);
        apply_b(12'd1, 12'h7C3); check("R3 a one", {41'd0, p}, 64'h7C3);
    endtask

    task automatic t_edge_bits;
        apply_b(12'h801, 12'h801);
        check("R4 low bit", {63'd0, p[0]}, 64'd1);
        check("R4 top bit", {63'd0, p[2*WB-2]}, 64'd1);
        apply_b(12'h800, 12'h7FF);
        check("R4 top bit clear", {63'd0, p[2*WB-2]}, 64'd0);
    endtask

    task automatic t_parity;
        logic [63:0] e;
        for (int n = 0; n < 40; n++) begin
            logic [WB-1:0] x = WB'($urandom);
            logic [WB-1:0] y = WB'($urandom);
            apply_b(x, y);
            e = {63'd0, (^x) & (^y)};
            check("R5 parity", {63'd0, ^p}, e);
        end
    endtask

    task automatic t_commute;
        logic [2*WB-2:0] first;
        for (int n = 0; n < 30; n++) begin
            logic [WB-1:0] x = WB'($urandom);
            logic [WB-1:0] y = WB'($urandom);
            apply_b(x, y); first = p;
            apply_b(y, x);
            check("R6 swap", {41'd0, p}, {41'd0, first});
        end
    endtask

    task automatic t_shift;
        for (int j = 0; j < WB; j++) begin
            apply_b(12'hB6D, WB'(1) << j);
            check("R7 shift", {41'd0, p}, 64'hB6D << j);
        end
    endtask

    task automatic t_slices;
        run_pair("R8 low slice", 12'h00F, 12'h00D);
        run_pair("R8 mid slice", 12'h0F0, 12'h0B0);
        run_pair("R8 high slice", 12'hF00, 12'h900);
        run_pair("R8 all ones", 12'hFFF, 12'hFFF);
        run_pair("R8 slice edges", 12'h198, 12'h198);
        run_pair("R8 cross slices", 12'h00F, 12'hF00);
    endtask

    task automatic t_exhaust_k1;
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++) begin
                @(posedge clk); a1 = 3'(x); b1 = 3'(y);
                @(negedge clk);
                check("R1 K=1", {59'd0, p1}, clmul(32'(x), 32'(y)));
            end
    endtask

    task automatic t_exhaust_k2;
        for (int x = 0; x < 64; x++)
            for (int y = 0; y < 64; y++) begin
                @(posedge clk); a2 = 6'(x); b2 = 6'(y);
                @(negedge clk);
                check("R1 K=2", {53'd0, p2}, clmul(32'(x), 32'(y)));
            end
    endtask

    task automatic t_random;
        for (int n = 0; n < 1500; n++)
            run_pair("R1 K=4 random", WB'($urandom), WB'($urandom));
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        a = '0; b = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_rest;
        t_zero;
        t_unit;
        t_edge_bits;
        t_parity;
        t_commute;
        t_shift;
        t_slices;
        t_exhaust_k1;
        t_exhaust_k2;
        t_random;
        finish_run;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule